// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block watches the byte stream of an incoming Ethernet frame and decides, from the six-byte destination address at its head, whether the frame should be kept. Bytes arrive one per valid beat. A start marker tags the first byte and an end marker tags the last. Static configuration inputs supply a 48-bit station address, a 64-entry multicast hash table held as two 32-bit words, and three mode bits: one that refuses broadcast, one that sends every address through the hash table, and one that keeps everything (promiscuous).

Three checks are possible, and one of them is picked for each frame. An all-ones destination is broadcast and is decided by the broadcast-refusal bit alone. A destination with the group bit set, or any destination while hash-for-all is on, is looked up in the hash table. Every other destination is compared exactly against the station address. A frame that fails its check is dropped, unless promiscuous mode is on. In that case it is kept and still reported as a miss. A frame that ends before six bytes is never filtered and always counts as a miss.

The controller has three states. ST_IDLE means no frame is open, ST_GATHER means destination bytes are being collected, and ST_HOLD means a decision is being presented. Its transitions are:
- start-beat: any state to ST_GATHER, on a start beat that does not complete the decision.
- decide: ST_GATHER, or a start beat from any state, to ST_HOLD, on the sixth byte or on an early end.
- stay: in every other case the state is unchanged.

Top module: `addr_filter`

## Requirements
- R1: After reset, dec_valid, dec_accept and dec_miss are all 0. Whenever dec_valid is 0, dec_accept and dec_miss are also 0.
- R2: A valid beat with in_sof high opens a frame and carries destination byte 0. Later valid beats carry bytes 1 to 5 in order. Valid beats without in_sof are ignored while no frame is open, that is after reset or after a decision.
- R3: The decision appears with dec_valid=1 in the cycle after the beat that carries the sixth byte. It then holds stable until the next start beat, and this includes the case where the sixth byte is also flagged as the end.
- R4: A destination of six 0xFF bytes gives dec_miss equal to cfg_bcast_reject. This rule takes precedence over the hash lookup, even though byte 0 has its group bit set.
- R5: When the exact compare is used, the destination matches if byte 0 equals cfg_addr_hi[15:8], byte 1 equals cfg_addr_hi[7:0], and bytes 2 to 5 equal cfg_addr_lo[31:24], [23:16], [15:8] and [7:0]. A match gives dec_accept=1 and dec_miss=0.
- R6: The hash lookup replaces the exact compare when bit 0 of destination byte 0 is 1, or when cfg_hash_all is 1.
- R7: The hash index is bits 31:26 of a 32-bit CRC register. The register starts at all ones. For each destination byte in order, and for each bit of that byte from bit 0 upward, the register shifts left by one, and it is XORed with 0x04C11DB7 when its old bit 31 differs from the data bit. Index values 0 to 31 select cfg_hash_lo[index], and values 32 to 63 select cfg_hash_hi[index-32]. A 0 table bit is a miss.
- R8: A miss gives dec_accept=0 and dec_miss=1 when cfg_promisc is 0, and dec_accept=1 and dec_miss=1 when cfg_promisc is 1.
- R9: A frame whose end beat comes before its sixth byte gives a decision in the cycle after that end beat, with dec_miss=1 and dec_accept=cfg_promisc. A start beat that is also an end beat is a one-byte frame.
- R10: Bytes after the sixth byte of a frame do not change the held decision.
- R11: A start beat arriving while a frame is being collected restarts collection with that byte as byte 0. dec_valid is 0 in the cycle after any start beat that is not also an end beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte beat valid |
| in_sof | input | 1 | Beat carries the first byte of a frame |
| in_eof | input | 1 | Beat carries the last byte of a frame |
| in_byte | input | 8 | Frame byte |
| cfg_addr_hi | input | 16 | Station address bytes 0 (15:8) and 1 (7:0) |
| cfg_addr_lo | input | 32 | Station address bytes 2 (31:24) to 5 (7:0) |
| cfg_hash_lo | input | 32 | Hash table entries 0 to 31 |
| cfg_hash_hi | input | 32 | Hash table entries 32 to 63 |
| cfg_bcast_reject | input | 1 | Treat broadcast as a miss |
| cfg_hash_all | input | 1 | Send every non-broadcast address to the hash table |
| cfg_promisc | input | 1 | Keep frames that miss |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Frame is kept |
| dec_miss | output | 1 | Destination failed its check |

## Verification
The hardest case to reach from the ports is a hash hit that lands in the upper table word, or in one chosen table word, because the CRC scatters the index. To get there, the bench works out the index of each candidate group address with its own model of R7. It steps through candidates until the index falls in the wanted word, sets only that one table bit, and then inverts the table so that the same frame must miss. Broadcast precedence is reached by sending all-ones while hash-for-all is on and the table is empty, so the hash path would answer differently.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_HOLD   = 2'd2
    } afl_state_e;

    localparam int unsigned CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // Advance the running CRC by one byte, feeding the byte's bits from bit 0 upward.
    function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ b[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/afl_capture.sv
module afl_capture #(
    parameter int unsigned NBYTES = 6,
    localparam int unsigned CNT_W = $clog2(NBYTES + 1),
    localparam int unsigned AW    = NBYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             restart,
    input  logic [7:0]       byte_in,
    output logic [AW-1:0]    dest_now,
    output logic [CNT_W-1:0] count_now
);

    logic [7:0]       bytes_q [NBYTES];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] slot;

    // A start beat always lands in slot 0, whatever the count says.
    assign slot      = restart ? '0 : cnt_q;
    assign count_now = slot + CNT_W'(1);

    for (genvar k = 0; k < NBYTES; k++) begin : g_slot
        assign dest_now[AW-1-8*k -: 8] = (take && slot == CNT_W'(k)) ? byte_in : bytes_q[k];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            bytes_q[k] <= 8'h00;
            else if (take && slot == CNT_W'(k))    bytes_q[k] <= byte_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (take)  cnt_q <= count_now;
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NBYTES));

endmodule

// File: rtl/afl_crc_hash.sv
module afl_crc_hash
    import addr_filt_pkg::*;
#(
    parameter int unsigned HASH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              restart,
    input  logic [7:0]        byte_in,
    output logic [HASH_W-1:0] hash_now
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_now;

    // A start beat reseeds the CRC so that the first byte sees all ones.
    assign crc_now  = crc_step_byte(restart ? CRC_SEED : crc_q, byte_in);
    assign hash_now = crc_now[CRC_W-1 -: HASH_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc_q <= CRC_SEED;
        else if (take)  crc_q <= crc_now;
    end

endmodule

// File: rtl/afl_match.sv
module afl_match #(
    parameter int unsigned NBYTES = 6,
    parameter int unsigned HASH_W = 6,
    localparam int unsigned AW    = NBYTES * 8,
    localparam int unsigned TBL   = 1 << HASH_W
) (
    input  logic [AW-1:0]     dest,
    input  logic [AW-1:0]     station,
    input  logic [HASH_W-1:0] hash_idx,
    input  logic [TBL-1:0]    table_bits,
    input  logic              bcast_reject,
    input  logic              hash_all,
    output logic              miss
);

    logic [NBYTES-1:0] byte_eq;
    logic [NBYTES-1:0] byte_ones;
    logic              group_bit;

    for (genvar k = 0; k < NBYTES; k++) begin : g_cmp
        assign byte_eq[k]   = dest[AW-1-8*k -: 8] == station[AW-1-8*k -: 8];
        assign byte_ones[k] = &dest[AW-1-8*k -: 8];
    end

    assign group_bit = dest[AW-8];

    always_comb begin
        if (&byte_ones)                  miss = bcast_reject;
        else if (group_bit || hash_all)  miss = !table_bits[hash_idx];
        else                             miss = !(&byte_eq);
    end

endmodule

// File: rtl/addr_filter.sv
module addr_filter
    import addr_filt_pkg::*;
#(
    parameter int unsigned HASH_W = 6,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_byte,
    input  logic [15:0]       cfg_addr_hi,
    input  logic [31:0]       cfg_addr_lo,
    input  logic [WORD_W-1:0] cfg_hash_lo,
    input  logic [WORD_W-1:0] cfg_hash_hi,
    input  logic              cfg_bcast_reject,
    input  logic              cfg_hash_all,
    input  logic              cfg_promisc,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              dec_miss
);

    localparam int unsigned NBYTES = 6;
    localparam int unsigned AW     = NBYTES * 8;
    localparam int unsigned CNT_W  = $clog2(NBYTES + 1);

    afl_state_e        state_q, state_d;
    logic              restart, take, full, early_end, decide;
    logic [AW-1:0]     dest_now;
    logic [CNT_W-1:0]  count_now;
    logic [HASH_W-1:0] hash_now;
    logic              match_miss;
    logic              accept_q, miss_q;

    assign restart   = in_valid && in_sof;
    assign take      = in_valid && (in_sof || state_q == ST_GATHER);
    assign full      = take && (count_now == CNT_W'(NBYTES));
    assign early_end = take && in_eof && !full;
    assign decide    = full || early_end;

    afl_capture #(.NBYTES(NBYTES)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .restart   (restart),
        .byte_in   (in_byte),
        .dest_now  (dest_now),
        .count_now (count_now)
    );

    afl_crc_hash #(.HASH_W(HASH_W)) u_hash (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .restart  (restart),
        .byte_in  (in_byte),
        .hash_now (hash_now)
    );

    afl_match #(.NBYTES(NBYTES), .HASH_W(HASH_W)) u_match (
        .dest         (dest_now),
        .station      ({cfg_addr_hi, cfg_addr_lo}),
        .hash_idx     (hash_now),
        .table_bits   ({cfg_hash_hi, cfg_hash_lo}),
        .bcast_reject (cfg_bcast_reject),
        .hash_all     (cfg_hash_all),
        .miss         (match_miss)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HOLD: begin
                if (decide)       state_d = ST_HOLD;
                else if (restart) state_d = ST_GATHER;
            end
            ST_GATHER: begin
                if (decide)       state_d = ST_HOLD;
            end
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            miss_q   <= 1'b0;
        end else if (decide) begin
            miss_q   <= early_end ? 1'b1 : match_miss;
            accept_q <= early_end ? cfg_promisc : (!match_miss || cfg_promisc);
        end else if (restart) begin
            accept_q <= 1'b0;
            miss_q   <= 1'b0;
        end
    end

    assign dec_valid  = (state_q == ST_HOLD);
    assign dec_accept = accept_q;
    assign dec_miss   = miss_q;

    assert_quiet_when_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && !dec_miss));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !restart) |=> (dec_valid && $stable(dec_accept) && $stable(dec_miss)));

    assert_drop_means_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> dec_miss);

    assert_early_end_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_eof && count_now < CNT_W'(NBYTES)) |=> (dec_valid && dec_miss));

    assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !in_eof) |=> !dec_valid);

endmodule

// File: tb/sim_addr_filter.sv
`timescale 1ns/1ps
module sim_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [15:0] cfg_addr_hi = 16'h0A1B;
    logic [31:0] cfg_addr_lo = 32'h2C3D4E5F;
    logic [31:0] cfg_hash_lo = '0, cfg_hash_hi = '0;
    logic        cfg_bcast_reject = 1'b0, cfg_hash_all = 1'b0, cfg_promisc = 1'b0;
    logic        dec_valid, dec_accept, dec_miss;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [47:0] STATION = 48'h0A1B2C3D4E5F;
    localparam logic [47:0] BCAST   = 48'hFFFFFFFFFFFF;

    always #4 clk = ~clk;

    addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_byte(in_byte), .cfg_addr_hi(cfg_addr_hi), .cfg_addr_lo(cfg_addr_lo),
        .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
        .cfg_bcast_reject(cfg_bcast_reject), .cfg_hash_all(cfg_hash_all),
        .cfg_promisc(cfg_promisc), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_miss(dec_miss)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_of(input logic [47:0] d);
        logic [31:0] c = 32'hFFFFFFFF;
        logic        fb;
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[31] ^ d[47 - 8*i - 7 + b];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic exp_miss(input logic [47:0] d);
        logic [63:0] tbl = {cfg_hash_hi, cfg_hash_lo};
        if (d == BCAST) return cfg_bcast_reject;
        if (d[40] || cfg_hash_all) return !tbl[hash_of(d)];
        return d != {cfg_addr_hi, cfg_addr_lo};
    endfunction

    // Called at a falling edge; the beat is captured at the next rising edge.
    task automatic beat(input bit s, input bit e, input logic [7:0] b);
        in_valid = 1'b1; in_sof = s; in_eof = e; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send(input logic [47:0] d, input int n, input bit eof_last);
        for (int i = 0; i < n; i++)
            beat(i == 0, eof_last && (i == n - 1), (i < 6) ? d[47 - 8*i -: 8] : 8'(8'hA0 + i));
    endtask

    task automatic check_dec(input string req, input logic [47:0] d);
        logic m = exp_miss(d);
        chk({req, " valid"}, 32'(dec_valid), 32'd1);
        chk({req, " miss"}, 32'(dec_miss), 32'(m));
        chk({req, " accept"}, 32'(dec_accept), 32'(!m || cfg_promisc));
    endtask

    task automatic t_reset();
        chk("R1 reset valid", 32'(dec_valid), 0);
        chk("R1 reset accept", 32'(dec_accept), 0);
        chk("R1 reset miss", 32'(dec_miss), 0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        for (int i = 0; i < 6; i++) beat(1'b0, 1'b0, STATION[47 - 8*i -: 8]);
        chk("R2 stray bytes before any start", 32'(dec_valid), 0);
        chk("R1 quiet accept while invalid", 32'(dec_accept), 0);
    endtask

    task automatic t_unicast();
        cfg_promisc = 1'b0;
        send(STATION, 6, 1'b1);
        check_dec("R5 station hit", STATION);
        chk("R5 hit accept", 32'(dec_accept), 1);
        send(48'h0A1B2C3D4E5E, 6, 1'b1);
        check_dec("R8 unicast miss dropped", 48'h0A1B2C3D4E5E);
        chk("R8 dropped accept", 32'(dec_accept), 0);
        cfg_promisc = 1'b1;
        send(48'h0A1B2C3D4E5E, 6, 1'b1);
        check_dec("R8 promiscuous keeps miss", 48'h0A1B2C3D4E5E);
        chk("R8 promisc miss flag", 32'(dec_miss), 1);
        cfg_promisc = 1'b0;
    endtask

    task automatic t_bcast();
        cfg_hash_lo = '0; cfg_hash_hi = '0; cfg_hash_all = 1'b1;
        cfg_bcast_reject = 1'b0;
        send(BCAST, 6, 1'b1);
        check_dec("R4 broadcast allowed over empty hash", BCAST);
        chk("R4 broadcast accept", 32'(dec_accept), 1);
        cfg_bcast_reject = 1'b1;
        send(BCAST, 6, 1'b1);
        check_dec("R4 broadcast refused", BCAST);
        chk("R4 refused accept", 32'(dec_accept), 0);
        cfg_bcast_reject = 1'b0; cfg_hash_all = 1'b0;
    endtask

    task automatic t_hash(input bit want_hi);
        logic [47:0] d;
        logic [5:0]  idx;
        logic [63:0] tbl;
        bit          found = 1'b0;
        for (int x = 0; x < 256 && !found; x++) begin
            d = {40'h01005E0000, 8'(x)};
            idx = hash_of(d);
            if (idx[5] == want_hi) found = 1'b1;
        end
        chk("R7 candidate found", 32'(found), 1);
        tbl = 64'd1 << idx;
        {cfg_hash_hi, cfg_hash_lo} = tbl;
        send(d, 6, 1'b1);
        check_dec(want_hi ? "R7 hash hit upper word" : "R7 hash hit lower word", d);
        chk("R6 group address hash hit", 32'(dec_accept), 1);
        {cfg_hash_hi, cfg_hash_lo} = ~tbl;
        send(d, 6, 1'b1);
        check_dec("R7 hash miss on cleared bit", d);
        chk("R7 cleared bit miss", 32'(dec_miss), 1);
        cfg_hash_lo = '0; cfg_hash_hi = '0;
    endtask

    task automatic t_hash_all();
        cfg_hash_all = 1'b1;
        send(STATION, 6, 1'b1);
        check_dec("R6 hash-all forces station through table", STATION);
        chk("R6 station missed in table", 32'(dec_miss), 1);
        cfg_hash_all = 1'b0;
    endtask

    task automatic t_timing();
        for (int i = 0; i < 5; i++) beat(i == 0, 1'b0, STATION[47 - 8*i -: 8]);
        chk("R3 no decision after five bytes", 32'(dec_valid), 0);
        beat(1'b0, 1'b0, STATION[7:0]);
        check_dec("R3 decision one cycle after sixth byte", STATION);
        repeat (3) @(negedge clk);
        chk("R3 held over idle cycles", 32'(dec_accept), 1);
        for (int i = 0; i < 4; i++) beat(1'b0, i == 3, 8'hFF);
        check_dec("R10 extra bytes ignored", STATION);
        for (int i = 0; i < 6; i++) beat(1'b0, 1'b0, 8'h00);
        check_dec("R2 non-start bytes after decision ignored", STATION);
    endtask

    task automatic t_short();
        cfg_promisc = 1'b0;
        send(STATION, 3, 1'b1);
        chk("R9 short frame valid", 32'(dec_valid), 1);
        chk("R9 short frame miss", 32'(dec_miss), 1);
        chk("R9 short frame dropped", 32'(dec_accept), 0);
        cfg_promisc = 1'b1;
        send(STATION, 1, 1'b1);
        chk("R9 one-byte frame miss", 32'(dec_miss), 1);
        chk("R9 one-byte promisc accept", 32'(dec_accept), 1);
        cfg_promisc = 1'b0;
    endtask

    task automatic t_restart();
        send(48'h112233445566, 3, 1'b0);
        chk("R11 valid low after start beat", 32'(dec_valid), 0);
        send(STATION, 6, 1'b0);
        check_dec("R11 restart uses new bytes", STATION);
        chk("R11 restart hit", 32'(dec_accept), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_unicast();
        t_bcast();
        t_hash(1'b0);
        t_hash(1'b1);
        t_hash_all();
        t_timing();
        t_short();
        t_restart();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule